// File: doc/BRIEF.md
# Majority-Vote Input Debouncer

This block cleans up a bank of slow general-purpose input lines that may bounce or carry short glitches. While filtering is switched on, it records every line on every clock into a per-line shift history sixteen samples deep. Each line's filtered level is then set by a majority decision over the newest part of that history. A run-time control field picks how many of the newest samples take part, so the same hardware can trade response time for noise rejection without being rebuilt.

The vote counts the ones in each line's window with an adder, not with a fixed majority gate. An odd window is judged directly. An even request is balanced: the oldest slot of the window is paired with a virtual slot so that the pair adds exactly one 1 and one 0, and the decision comes down to the newest odd-length part. When filtering is switched off, the history is frozen and each filtered line simply tracks its raw input. The filtered output is a register.

Top module: `gpio_debounce_vote`

## Requirements
- R1: During synchronous reset and on the first sample after it, every history bit and every output bit is 0.
- R2: While `deb_en` is 1, every clock edge shifts `raw_in` into history slot 0 (the newest) and moves slot k to slot k+1. The oldest of the 16 slots is dropped.
- R3: While `deb_en` is 0, the history keeps its contents unchanged whatever `raw_in` does.
- R4: While `deb_en` is 0, `filt_out` takes the value `raw_in` had at the previous clock edge.
- R5: The window length L is `win_sel`+1 (1 to 16 samples), counted from slot 0 upward.
- R6: For odd L, a line's output is 1 exactly when the number of ones in its L newest slots is greater than L/2.
- R7: For even L, a line's output equals the majority of its L-1 newest slots. A 2-slot window follows slot 0, and a 4-slot window with newest-first history 1,1,0,0 gives 1.
- R8: The output is registered. The vote over the history as it stood before a clock edge appears on `filt_out` after that edge, so a new raw level first reaches the output two edges after it is sampled.
- R9: Each output bit depends only on the history of the line with the same index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_in | input | 8 | Raw input lines |
| deb_en | input | 1 | 1: sample and vote; 0: freeze history and pass the raw value through |
| win_sel | input | 4 | Window length minus one |
| filt_out | output | 8 | Filtered lines |

## Verification
Two events can fall on the same edge: a change of `win_sel` and a new sample shifting into the history. The vote registered at the next edge must then use both the new window and the new history. The bench changes the window on the same cycle as a new pattern and compares the result with a model that applies each edge in order. It also drops `deb_en` on a cycle when a vote is due. Then it re-enables filtering with a one-slot window, which proves that the frozen history came through unchanged and that the vote and the raw pass-through never mix.

// File: rtl/dbv_pkg.sv
package dbv_pkg;
  localparam int unsigned DEF_LINES = 8;
  localparam int unsigned DEF_DEPTH = 16;
  localparam int unsigned DEF_SELW  = 4;

  // Requested window length from the select field.
  function automatic int unsigned win_len(input int unsigned sel_val);
    return sel_val + 1;
  endfunction
endpackage

// File: rtl/dbv_history.sv
module dbv_history #(
  parameter int unsigned LINES = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   shift_en,
  input  logic [LINES-1:0]       din,
  output logic [DEPTH*LINES-1:0] hist
);
  localparam int unsigned KEEP = (DEPTH - 1) * LINES;

  // Slot s occupies bits [s*LINES +: LINES]; slot 0 is newest.
  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
    end else if (shift_en) begin
      hist <= {hist[KEEP-1:0], din};
    end
  end
endmodule

// File: rtl/dbv_vote.sv
module dbv_vote #(
  parameter int unsigned LINES = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned SELW  = 4
) (
  input  logic [DEPTH*LINES-1:0] hist,
  input  logic [SELW-1:0]        sel,
  output logic [LINES-1:0]       vote
);
  // Count ones in the window. For an even length, the oldest slot is
  // swapped for a balanced pair: one counted 1 and one more slot in total.
  function automatic logic line_vote(input logic [DEPTH-1:0] h,
                                     input logic [SELW-1:0]  s);
    int unsigned len, used, cnt, total;
    logic bal;
    len   = dbv_pkg::win_len(32'(s));
    bal   = ~len[0];
    used  = len - 32'(bal);
    cnt   = 32'(bal);
    for (int unsigned k = 0; k < DEPTH; k++) begin
      if (k < used && h[k]) cnt = cnt + 1;
    end
    total = len + 32'(bal);
    return (2 * cnt) > total;
  endfunction

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [DEPTH-1:0] col;
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      assign col[s] = hist[s*LINES + l];
    end
    always_comb vote[l] = line_vote(col, sel);
  end
endmodule

// File: rtl/gpio_debounce_vote.sv
module gpio_debounce_vote #(
  parameter int unsigned LINES = dbv_pkg::DEF_LINES,
  parameter int unsigned DEPTH = dbv_pkg::DEF_DEPTH,
  parameter int unsigned SELW  = dbv_pkg::DEF_SELW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] raw_in,
  input  logic             deb_en,
  input  logic [SELW-1:0]  win_sel,
  output logic [LINES-1:0] filt_out
);
  localparam int unsigned HBITS = DEPTH * LINES;

  logic [HBITS-1:0] hist_flat;
  logic [LINES-1:0] vote_w;
  logic [LINES-1:0] filt_q;

  dbv_history #(.LINES(LINES), .DEPTH(DEPTH)) u_hist (
    .clk(clk), .rst(rst), .shift_en(deb_en), .din(raw_in), .hist(hist_flat)
  );

  dbv_vote #(.LINES(LINES), .DEPTH(DEPTH), .SELW(SELW)) u_vote (
    .hist(hist_flat), .sel(win_sel), .vote(vote_w)
  );

  always_ff @(posedge clk) begin
    if (rst)         filt_q <= '0;
    else if (deb_en) filt_q <= vote_w;
    else             filt_q <= raw_in;
  end

  assign filt_out = filt_q;
endmodule

// File: rtl/dbv_checker.sv
module dbv_checker #(
  parameter int unsigned LINES = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned SELW  = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic [LINES-1:0]       raw_in,
  input logic                   deb_en,
  input logic [SELW-1:0]        win_sel,
  input logic [LINES-1:0]       filt_out,
  input logic [DEPTH*LINES-1:0] hist_flat
);
  localparam int unsigned HB = DEPTH * LINES;

  // R2
  newest_slot_chk: assert property (@(posedge clk) disable iff (rst)
    deb_en |=> hist_flat[LINES-1:0] == $past(raw_in));

  // R2
  slot_move_chk: assert property (@(posedge clk) disable iff (rst)
    deb_en |=> hist_flat[HB-1:LINES] == $past(hist_flat[HB-LINES-1:0]));

  // R3
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !deb_en |=> $stable(hist_flat));

  // R4
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    !deb_en |=> filt_out == $past(raw_in));

  // R8
  single_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (deb_en && win_sel == '0) |=> filt_out == $past(hist_flat[LINES-1:0]));
endmodule

bind gpio_debounce_vote dbv_checker #(.LINES(LINES), .DEPTH(DEPTH), .SELW(SELW)) u_chk (
  .clk(clk), .rst(rst), .raw_in(raw_in), .deb_en(deb_en), .win_sel(win_sel),
  .filt_out(filt_out), .hist_flat(hist_flat)
);

// File: tb/gpio_debounce_vote_test.sv
`timescale 1ns/1ps
module gpio_debounce_vote_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] raw_in = 8'h00;
  logic       deb_en = 1'b0;
  logic [3:0] win_sel = 4'd0;
  logic [7:0] filt_out;

  int checks = 0;
  int failures = 0;

  logic [7:0] mh [16];
  logic [7:0] exp_q = 8'h00;

  always #5 clk = ~clk;

  gpio_debounce_vote uut (
    .clk(clk), .rst(rst), .raw_in(raw_in), .deb_en(deb_en),
    .win_sel(win_sel), .filt_out(filt_out)
  );

  // Majority over the newest m slots, where m is L for odd L and L-1 for even L.
  function automatic logic [7:0] model_vote(input logic [3:0] s);
    logic [7:0] r;
    int len, m, ones;
    len = int'(s) + 1;
    m = (len % 2 == 1) ? len : len - 1;
    for (int l = 0; l < 8; l++) begin
      ones = 0;
      for (int k = 0; k < m; k++) if (mh[k][l]) ones++;
      r[l] = (2 * ones > m);
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // One clock: model the edge, then compare away from it.
  task automatic tick(input string tag);
    @(posedge clk);
    if (rst) begin
      for (int k = 0; k < 16; k++) mh[k] = 8'h00;
      exp_q = 8'h00;
    end else if (deb_en) begin
      exp_q = model_vote(win_sel);
      for (int k = 15; k > 0; k--) mh[k] = mh[k-1];
      mh[0] = raw_in;
    end else begin
      exp_q = raw_in;
    end
    @(negedge clk);
    check(tag, filt_out, exp_q);
  endtask

  task automatic t_reset();
    rst = 1'b1; raw_in = 8'hFF; deb_en = 1'b1;
    tick("R1 reset");
    tick("R1 reset");
    rst = 1'b0; raw_in = 8'h00; win_sel = 4'd15;
    tick("R1 first vote after reset");
  endtask

  task automatic t_passthrough();
    deb_en = 1'b0;
    raw_in = 8'hA5; tick("R4 pass");
    raw_in = 8'h3C; tick("R4 pass");
    raw_in = 8'h00; tick("R4 pass");
  endtask

  task automatic t_latency();
    deb_en = 1'b1; win_sel = 4'd0;
    raw_in = 8'h00; tick("R2 fill");
    raw_in = 8'h5A; tick("R8 sampled, output not yet changed");
    check("R8 old level kept", filt_out, 8'h00);
    raw_in = 8'h00; tick("R8 vote appears");
    check("R8 new level", filt_out, 8'h5A);
  endtask

  task automatic t_depth();
    deb_en = 1'b1; win_sel = 4'd15;
    for (int i = 0; i < 16; i++) begin
      raw_in = (i < 8) ? 8'hFF : 8'h0F;
      tick("R2 R7 depth-16 request");
    end
    for (int i = 0; i < 6; i++) begin
      raw_in = 8'hF0;
      tick("R2 R7 shifting oldest out");
    end
  endtask

  task automatic t_odd_even();
    logic [7:0] pat [6];
    pat[0] = 8'h00; pat[1] = 8'h00; pat[2] = 8'hC3;
    pat[3] = 8'hC5; pat[4] = 8'h96; pat[5] = 8'h99;
    deb_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      raw_in = pat[i]; win_sel = 4'd2; tick("R6 R9 odd window of 3");
    end
    win_sel = 4'd4; raw_in = 8'h11; tick("R6 window of 5");
    // sel and sample change together
    win_sel = 4'd3; raw_in = 8'hE7; tick("R5 R7 window of 4 with new sample");
    win_sel = 4'd1; raw_in = 8'h18; tick("R7 window of 2");
    win_sel = 4'd6; raw_in = 8'h42; tick("R6 window of 7");
  endtask

  task automatic t_even_tie();
    deb_en = 1'b1; win_sel = 4'd0;
    raw_in = 8'h00; tick("R7 prep");
    raw_in = 8'h00; tick("R7 prep");
    raw_in = 8'hFF; tick("R7 prep");
    raw_in = 8'hFF; tick("R7 prep");
    // newest first: 1,1,0,0 -> majority of newest three is 1
    win_sel = 4'd3; raw_in = 8'h00; tick("R7 even window 1,1,0,0");
    raw_in = 8'h00; tick("R7 even window vote");
  endtask

  task automatic t_hold();
    deb_en = 1'b1; win_sel = 4'd0;
    for (int i = 0; i < 3; i++) begin raw_in = 8'h6C; tick("R2 fill"); end
    deb_en = 1'b0;
    for (int i = 0; i < 4; i++) begin raw_in = 8'h00; tick("R3 R4 frozen"); end
    deb_en = 1'b1; raw_in = 8'h00; tick("R3 held slot 0");
    check("R3 held history seen at output", filt_out, 8'h6C);
    tick("R3 resumed sampling");
  endtask

  initial begin : watchdog
    #1000000;
    failures++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_passthrough();
    t_latency();
    t_depth();
    t_odd_even();
    t_even_tie();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule